// File: doc/BRIEF.md
# Supervisory Reset Generator with Bus-Activity Watchdog

This block drives a system reset from three causes: the initial power-up of the chip, a digital supply-low flag from an external comparator, and a watchdog. The watchdog counts millisecond ticks. It restarts only when it sees a START condition followed by a STOP condition on the monitored two-wire serial bus lines. If the host processor stops talking on the bus for longer than the selected period, the block pulls reset. The reset is offered in an active-high form and an active-low form.

Every duration is a count of `tick_ms` pulses, and each count is a parameter, so a simulation can use short values. A 2-bit period select chooses one of three timeouts, or turns the watchdog off. The block copies this code into its own latch only at a restart or while reset is active. A change on the pins therefore never shortens or stretches a count that is already running.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1. After `por_n` goes high, `rst_out` stays 1 until HOLD_TICKS ticks have been counted, and it falls on the clock edge that samples the last of those ticks.
- R2: `rst_out_n` is always the exact complement of `rst_out`.
- R3: In any cycle where `supply_low` is 1, `rst_out` is 1, with no added latency.
- R4: Once `supply_low` clears, reset is held for HOLD_TICKS further ticks. If `supply_low` returns during a hold, the hold count starts again from zero.
- R5: The period code selects the timeout: 2'b00 gives WD_TICKS_LONG ticks, 2'b01 gives WD_TICKS_MID ticks, 2'b10 gives WD_TICKS_SHORT ticks, and 2'b11 turns the watchdog off. After power-up the latched code is 2'b11.
- R6: A START (SDA falling while SCL is high on two consecutive samples) followed by a STOP (SDA rising while SCL is high) restarts the watchdog count. A STOP that has no START before it does not restart the count. A START that has no STOP after it does not restart the count either.
- R7: When the watchdog is enabled and counts its full period of ticks without a restart, `rst_out` rises on the next clock edge and is then held for HOLD_TICKS ticks.
- R8: While reset is active, the watchdog count is held at zero. After release, it counts a full period from zero.
- R9: A change of `period_sel` is latched only at a restart or while reset is active. A count already in progress finishes with the old period.
- R10: A restart that falls in the same cycle as the tick that would end the period wins. No reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle pulse per millisecond time unit |
| supply_low | input | 1 | Supply-below-threshold flag from the external comparator |
| scl_in | input | 1 | Synchronized sample of the bus clock line |
| sda_in | input | 1 | Synchronized sample of the bus data line |
| period_sel | input | 2 | Watchdog period code |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a bus restart and the final watchdog tick. The bench provokes this by placing the STOP edge and a tick pulse in one cycle, exactly when the count sits one short of the period. It expects reset to stay low and a full new period to follow.

The second pair is a supply-low assertion and a watchdog expiry. The bench raises the flag on the expiring tick and expects one reset. That reset must be held for exactly HOLD_TICKS ticks after the flag clears, without being stretched or shortened by the expiry that happened alongside it.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        PER_LONG  = 2'b00,
        PER_MID   = 2'b01,
        PER_SHORT = 2'b10,
        PER_OFF   = 2'b11
    } period_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic armed;
    } bus_st_t;

endpackage

// File: rtl/sr_bus_mon.sv
module sr_bus_mon
    import sr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic scl_in,
    input  logic sda_in,
    output logic kick
);
    bus_st_t st_d, st_q;
    logic    start_c, stop_c;

    always_comb begin
        st_d     = st_q;
        st_d.scl = scl_in;
        st_d.sda = sda_in;
        start_c  = st_q.scl && scl_in && st_q.sda && !sda_in;
        stop_c   = st_q.scl && scl_in && !st_q.sda && sda_in;
        kick     = 1'b0;
        if (clr) begin
            st_d.armed = 1'b0;
        end else if (start_c) begin
            st_d.armed = 1'b1;
        end else if (stop_c && st_q.armed) begin
            kick       = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{scl: 1'b1, sda: 1'b1, armed: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sr_hold.sv
module sr_hold #(
    parameter int HOLD_TICKS = 200,
    parameter int CW         = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic supply_low,
    input  logic retrig,
    output logic rst_act
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (supply_low || retrig) begin
            h_d.active = 1'b1;
            h_d.cnt    = '0;
        end else if (h_q.active && tick) begin
            if (h_q.cnt == CW'(HOLD_TICKS - 1)) begin
                h_d.active = 1'b0;
                h_d.cnt    = '0;
            end else begin
                h_d.cnt = h_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) h_q <= '{active: 1'b1, cnt: '0};
        else        h_q <= h_d;
    end

    assign rst_act = h_q.active || supply_low;
endmodule

// File: rtl/sr_wdog.sv
module sr_wdog
    import sr_pkg::*;
#(
    parameter int T_LONG  = 1400,
    parameter int T_MID   = 600,
    parameter int T_SHORT = 200,
    parameter int CW      = 11
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          tick,
    input  logic          kick,
    input  logic          hold,
    input  logic [1:0]    period_sel,
    output logic          expire,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        period_e       sel;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t           w_d, w_q;
    logic [CW-1:0] limit;

    always_comb begin
        case (w_q.sel)
            PER_LONG:  limit = CW'(T_LONG);
            PER_MID:   limit = CW'(T_MID);
            PER_SHORT: limit = CW'(T_SHORT);
            default:   limit = '1;
        endcase
    end

    always_comb begin
        w_d    = w_q;
        expire = 1'b0;
        if (hold || kick) begin
            w_d.cnt = '0;
            w_d.sel = period_e'(period_sel);
        end else if (w_q.sel != PER_OFF && tick) begin
            if (w_q.cnt == limit - 1'b1) begin
                expire  = 1'b1;
                w_d.cnt = '0;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) w_q <= '{sel: PER_OFF, cnt: '0};
        else        w_q <= w_d;
    end

    assign cnt = w_q.cnt;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int HOLD_TICKS     = 200,
    parameter int WD_TICKS_LONG  = 1400,
    parameter int WD_TICKS_MID   = 600,
    parameter int WD_TICKS_SHORT = 200
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick_ms,
    input  logic       supply_low,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] period_sel,
    output logic       rst_out_n,
    output logic       rst_out
);
    localparam int WD_MAX01 = (WD_TICKS_LONG > WD_TICKS_MID) ? WD_TICKS_LONG : WD_TICKS_MID;
    localparam int WD_MAX   = (WD_MAX01 > WD_TICKS_SHORT) ? WD_MAX01 : WD_TICKS_SHORT;
    localparam int WD_CW    = $clog2(WD_MAX + 1);
    localparam int HOLD_CW  = $clog2(HOLD_TICKS + 1);

    logic             rst_act;
    logic             kick;
    logic             wd_expire;
    logic [WD_CW-1:0] wd_cnt;

    sr_bus_mon u_bus (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (rst_act),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .kick   (kick)
    );

    sr_wdog #(
        .T_LONG  (WD_TICKS_LONG),
        .T_MID   (WD_TICKS_MID),
        .T_SHORT (WD_TICKS_SHORT),
        .CW      (WD_CW)
    ) u_wd (
        .clk        (clk),
        .por_n      (por_n),
        .tick       (tick_ms),
        .kick       (kick),
        .hold       (rst_act),
        .period_sel (period_sel),
        .expire     (wd_expire),
        .cnt        (wd_cnt)
    );

    sr_hold #(
        .HOLD_TICKS (HOLD_TICKS),
        .CW         (HOLD_CW)
    ) u_hold (
        .clk        (clk),
        .por_n      (por_n),
        .tick       (tick_ms),
        .supply_low (supply_low),
        .retrig     (wd_expire),
        .rst_act    (rst_act)
    );

    assign rst_out   = rst_act;
    assign rst_out_n = ~rst_act;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          por_n,
    input logic          tick_ms,
    input logic          supply_low,
    input logic          rst_out,
    input logic          rst_out_n,
    input logic          wd_expire,
    input logic [CW-1:0] wd_cnt
);
    AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!por_n)
        supply_low |-> (rst_out && !rst_out_n)); // R3

    AST_HOLD_AFTER_LOW: assert property (@(posedge clk) disable iff (!por_n)
        $fell(supply_low) |-> rst_out); // R4

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> $past(tick_ms)); // R1

    AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |=> rst_out); // R7

    AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        rst_out |=> (wd_cnt == '0)); // R8

    AST_NO_EXPIRE_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |-> !rst_out); // R8
endmodule

bind rst_supervisor rst_supervisor_chk #(.CW(WD_CW)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .tick_ms    (tick_ms),
    .supply_low (supply_low),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .wd_expire  (wd_expire),
    .wd_cnt     (wd_cnt)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
    localparam int HOLD = 4;
    localparam int WL   = 8;
    localparam int WM   = 6;
    localparam int WS   = 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       supply_low = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [1:0] period_sel = 2'b11;
    logic       rst_out_n, rst_out;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rst_supervisor #(
        .HOLD_TICKS (HOLD), .WD_TICKS_LONG (WL),
        .WD_TICKS_MID (WM), .WD_TICKS_SHORT (WS)
    ) u_dut (
        .clk (clk), .por_n (por_n), .tick_ms (tick_ms),
        .supply_low (supply_low), .scl_in (scl_in), .sda_in (sda_in),
        .period_sel (period_sel), .rst_out_n (rst_out_n), .rst_out (rst_out)
    );

    // bits: {group, supply_low, tick, expected rst}; group 0 = power-on, 1 = supply-low
    localparam logic [3:0] VEC [14] = '{
        4'b0011, 4'b0001, 4'b0011, 4'b0011, 4'b0010, 4'b0000, 4'b1101,
        4'b1011, 4'b1011, 4'b1111, 4'b1011, 4'b1011, 4'b1011, 4'b1010
    };

    task automatic chk(input logic exp, input string tag);
        n_run++;
        if (rst_out !== exp || rst_out_n !== ~exp) begin
            n_fail++;
            $display("FAIL %s (R2 pair): rst_out=%b rst_out_n=%b expected %b/%b",
                     tag, rst_out, rst_out_n, exp, ~exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick_ms = t;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic kick(input logic t_on_stop);
        scl_in = 1'b1; sda_in = 1'b1; cyc(1'b0);
        sda_in = 1'b0; cyc(1'b0);
        scl_in = 1'b0; cyc(1'b0);
        scl_in = 1'b1; cyc(1'b0);
        sda_in = 1'b1; cyc(t_on_stop);
    endtask

    task automatic hold_out(input string tag);
        ticks(HOLD - 1);
        chk(1'b1, {tag, " hold"});
        ticks(1);
        chk(1'b0, {tag, " release"});
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(1'b1, "R1 during power-on");
        por_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            supply_low = VEC[i][2];
            cyc(VEC[i][1]);
            chk(VEC[i][0], VEC[i][3] ? $sformatf("R3/R4 vec %0d", i)
                                     : $sformatf("R1 vec %0d", i));
        end

        // R5: latched code after power-up is off
        ticks(20);
        chk(1'b0, "R5 disabled after power-up");

        // R5 short period, R7 hold after expiry
        period_sel = 2'b10;
        kick(1'b0);
        ticks(WS - 1);
        chk(1'b0, "R5 short before expiry");
        ticks(1);
        chk(1'b1, "R7 short expiry");
        hold_out("R7");

        // R8 counting from zero after release
        ticks(WS - 1);
        chk(1'b0, "R8 count from zero");
        ticks(1);
        chk(1'b1, "R8 expiry after release");
        hold_out("R8");

        // R6 restart by START then STOP
        ticks(WS - 1);
        kick(1'b0);
        ticks(WS - 1);
        chk(1'b0, "R6 restart taken");
        ticks(1);
        chk(1'b1, "R6 expiry after restart");
        hold_out("R6");

        // R6 lone STOP does not restart
        ticks(WS - 1);
        scl_in = 1'b0; cyc(1'b0);
        sda_in = 1'b0; cyc(1'b0);
        scl_in = 1'b1; cyc(1'b0);
        sda_in = 1'b1; cyc(1'b0);
        chk(1'b0, "R6 lone stop no reset yet");
        ticks(1);
        chk(1'b1, "R6 lone stop ignored");
        hold_out("R6 stop");

        // R6 lone START does not restart
        ticks(WS - 1);
        sda_in = 1'b0; cyc(1'b0);
        scl_in = 1'b0; cyc(1'b0);
        sda_in = 1'b1; cyc(1'b0);
        scl_in = 1'b1; cyc(1'b0);
        ticks(1);
        chk(1'b1, "R6 lone start ignored");
        hold_out("R6 start");

        // R9 mid-count code change keeps the old period
        period_sel = 2'b00;
        ticks(WS - 1);
        chk(1'b0, "R9 before old-period end");
        ticks(1);
        chk(1'b1, "R9 old period used");
        hold_out("R9");

        // R5 long period, loaded during reset
        ticks(WL - 1);
        chk(1'b0, "R5 long before expiry");
        ticks(1);
        chk(1'b1, "R5 long expiry");
        period_sel = 2'b01;
        hold_out("R5 long");
        ticks(WM - 1);
        chk(1'b0, "R5 mid before expiry");
        ticks(1);
        chk(1'b1, "R5 mid expiry");
        period_sel = 2'b10;
        hold_out("R5 mid");

        // R10 restart on the final tick wins
        ticks(WS - 1);
        kick(1'b1);
        chk(1'b0, "R10 restart beats expiry");
        ticks(WS - 1);
        chk(1'b0, "R10 full period after restart");
        ticks(1);
        chk(1'b1, "R10 expiry afterwards");
        hold_out("R10");

        // R4 supply-low in the expiry cycle
        ticks(WS - 1);
        supply_low = 1'b1;
        cyc(1'b1);
        chk(1'b1, "R4 low with expiry");
        cyc(1'b1);
        cyc(1'b0);
        supply_low = 1'b0;
        cyc(1'b0);
        chk(1'b1, "R4 held after low clears");
        hold_out("R4 coincident");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule